// File: doc/BRIEF.md
# Dual-Mode Host Register Access Port

This block connects an external asynchronous 16-bit processor bus to an on-chip bank of configuration words. The host presents a 7-bit word address, a 16-bit data value, an active-low select and two strobe pins. A mode pin decides how the two strobe pins are read. With the mode pin low, the first pin is a write strobe and the second is a read strobe, both active low. With the mode pin high, the first pin is a data strobe and the second gives the transfer direction: low for write, high for read.

Every bus pin passes through a two-stage synchroniser into the system clock domain. Writes are taken on the end of the strobe, which is its low-to-high transition. Each write goes into the internal register bank and is also shown on the chip side as a one-cycle write pulse with its address and data. Reads drive the addressed word as a pad output value with a separate output enable. The enable is high only while a read access is active. At all other times the bus is released and the output value is zero.

Top module: `hostbus_port`

## Requirements
- R1: After the active-low reset, every register word reads back as zero. The write pulse and the output enable are low.
- R2: Split mode (mode pin 0): when the first strobe pin rises while select is low, exactly one write pulse occurs, carrying the address and data. The addressed word then holds that data.
- R3: Split mode: while select and the second strobe pin (the read strobe) are both low, the output enable is high and the output value is the addressed word.
- R4: Joined mode (mode pin 1): when the first strobe pin (the data strobe) rises while select and the direction pin are low, exactly one write pulse occurs and the addressed word is updated.
- R5: Joined mode: while select is low, the data strobe is low and the direction pin is high, the output enable is high and the output value is the addressed word.
- R6: While select is high, no strobe activity causes a write pulse or drives the bus, and the register contents do not change.
- R7: Joined mode: a data-strobe rise while the direction pin is high produces no write pulse and changes no word.
- R8: Outside a read access the output enable is low and the output value is zero.
- R9: A write pulse appears on the third rising clock edge after the strobe rise is applied. The read enable follows the pins with the same three-edge latency.
- R10: A strobe held high for many cycles produces only one write pulse. The write pulse never lasts two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hb_data_i | input | 16 | Bus data from the host (bit 15 MSB) |
| hb_addr_i | input | 7 | Word address (bit 6 MSB) |
| hb_sel_n_i | input | 1 | Active-low select |
| hb_stb_a_n_i | input | 1 | Write strobe (split) or data strobe (joined), active low |
| hb_stb_b_i | input | 1 | Active-low read strobe (split) or direction, 1 = read (joined) |
| hb_mode_i | input | 1 | Strobe convention: 0 split, 1 joined |
| hb_data_o | output | 16 | Read data toward the pad |
| hb_data_oe_o | output | 1 | Pad output enable |
| reg_wr_o | output | 1 | One-cycle write pulse |
| reg_addr_o | output | 7 | Address of the last write |
| reg_data_o | output | 16 | Data of the last write |

## Verification
In split mode the read strobe may stay low while the write strobe ends. The same clock edge then both stores a word and drives that word onto the bus. The bench provokes this with a directed case: it holds a read of one address open and completes a write to the same address. It then requires exactly one write pulse, an enable that stays high throughout, and output data that settles to the newly written value within a few cycles. Randomised sequences of both modes, with occasional unselected and read-direction strobes, are compared against a bench-side word model.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

   // Strobe convention selected by the mode pin
   typedef enum logic {
      STB_SPLIT  = 1'b0,
      STB_JOINED = 1'b1
   } strobe_mode_e;

   // Control pins as they cross into the clock domain
   typedef struct packed {
      logic mode;
      logic stb_b;
      logic stb_a;
      logic sel_n;
   } ctl_pins_t;

   localparam ctl_pins_t CTL_IDLE = '{mode: 1'b0, stb_b: 1'b1, stb_a: 1'b1, sel_n: 1'b1};

endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
   parameter int               W       = 8,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[gi] <= RST_VAL;
            else        stage_q[gi] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[gi] <= RST_VAL;
            else        stage_q[gi] <= stage_q[gi-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hostbus_strobe_dec.sv
module hostbus_strobe_dec
   import hostbus_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ctl_pins_t ctl,
   output logic      wr_hit,
   output logic      rd_req
);

   logic         stb_a_q;
   logic         wr_dir_ok;
   strobe_mode_e mode;

   assign mode = strobe_mode_e'(ctl.mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_a_q <= 1'b1;
      else        stb_a_q <= ctl.stb_a;
   end

   always_comb begin
      rd_req    = 1'b0;
      wr_dir_ok = 1'b0;
      case (mode)
         STB_SPLIT: begin
            rd_req    = ~ctl.sel_n & ~ctl.stb_b;
            wr_dir_ok = 1'b1;
         end
         STB_JOINED: begin
            rd_req    = ~ctl.sel_n & ctl.stb_b & ~ctl.stb_a;
            wr_dir_ok = ~ctl.stb_b;
         end
         default: begin
            rd_req    = 1'b0;
            wr_dir_ok = 1'b0;
         end
      endcase
      wr_hit = ~ctl.sel_n & ctl.stb_a & ~stb_a_q & wr_dir_ok;
   end

endmodule

// File: rtl/hostbus_regs.sv
module hostbus_regs #(
   parameter int              DATA_W     = 16,
   parameter int              ADDR_W     = 7,
   parameter int              WORDS      = 128,
   parameter logic [DATA_W-1:0] RESET_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 word_q[gi] <= RESET_WORD;
         else if (we && (waddr == ADDR_W'(gi)))      word_q[gi] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (raddr == ADDR_W'(i)) rdata = word_q[i];
      end
   end

endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
   import hostbus_pkg::*;
#(
   parameter int                DATA_W      = 16,
   parameter int                ADDR_W      = 7,
   parameter int                WORDS       = 128,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] RESET_WORD  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] hb_data_i,
   input  logic [ADDR_W-1:0] hb_addr_i,
   input  logic              hb_sel_n_i,
   input  logic              hb_stb_a_n_i,
   input  logic              hb_stb_b_i,
   input  logic              hb_mode_i,
   output logic [DATA_W-1:0] hb_data_o,
   output logic              hb_data_oe_o,
   output logic              reg_wr_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic [DATA_W-1:0] reg_data_o
);

   localparam int CTL_W = $bits(ctl_pins_t);
   localparam int SYN_W = CTL_W + ADDR_W + DATA_W;
   localparam logic [SYN_W-1:0] SYN_IDLE = {CTL_IDLE, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

   if (SYNC_STAGES < 2 || SYNC_STAGES > 12) begin : g_bad_sync
      $error("hostbus_port: SYNC_STAGES must lie in 2..12");
   end
   if (WORDS < 1 || WORDS > (1 << ADDR_W)) begin : g_bad_words
      $error("hostbus_port: WORDS must fit the address range");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("hostbus_port: widths must be positive");
   end

   ctl_pins_t          ctl_raw;
   ctl_pins_t          ctl_s;
   logic [ADDR_W-1:0]  addr_s;
   logic [DATA_W-1:0]  data_s;
   logic [SYN_W-1:0]   syn_in;
   logic [SYN_W-1:0]   syn_out;
   logic               wr_hit;
   logic               rd_req;
   logic [DATA_W-1:0]  rdata;

   assign ctl_raw = '{mode: hb_mode_i, stb_b: hb_stb_b_i, stb_a: hb_stb_a_n_i, sel_n: hb_sel_n_i};
   assign syn_in  = {ctl_raw, hb_addr_i, hb_data_i};

   hostbus_sync #(
      .W       (SYN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYN_IDLE)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (syn_in),
      .q     (syn_out)
   );

   assign {ctl_s, addr_s, data_s} = syn_out;

   hostbus_strobe_dec i_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ctl_s),
      .wr_hit (wr_hit),
      .rd_req (rd_req)
   );

   hostbus_regs #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .WORDS      (WORDS),
      .RESET_WORD (RESET_WORD)
   ) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_hit),
      .waddr (addr_s),
      .wdata (data_s),
      .raddr (addr_s),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_wr_o     <= 1'b0;
         reg_addr_o   <= '0;
         reg_data_o   <= '0;
         hb_data_oe_o <= 1'b0;
         hb_data_o    <= '0;
      end else begin
         reg_wr_o     <= wr_hit;
         if (wr_hit) begin
            reg_addr_o <= addr_s;
            reg_data_o <= data_s;
         end
         hb_data_oe_o <= rd_req;
         hb_data_o    <= rd_req ? rdata : '0;
      end
   end

endmodule

// File: rtl/hostbus_port_chk.sv
module hostbus_port_chk
   import hostbus_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hb_sel_n_i,
   input logic              hb_stb_a_n_i,
   input logic              hb_stb_b_i,
   input logic              hb_mode_i,
   input logic [DATA_W-1:0] hb_data_o,
   input logic              hb_data_oe_o,
   input logic              reg_wr_o
);

   localparam int DEPTH = SYNC_STAGES + 2;

   ctl_pins_t  pipe [DEPTH];
   ctl_pins_t  now_p;
   ctl_pins_t  prev_p;
   logic [4:0] warm_q;
   logic       ready;
   logic       rd_now;

   always_ff @(posedge clk) begin
      pipe[0] <= '{mode: hb_mode_i, stb_b: hb_stb_b_i, stb_a: hb_stb_a_n_i, sel_n: hb_sel_n_i};
      for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     warm_q <= '0;
      else if (warm_q != 5'(DEPTH))   warm_q <= warm_q + 5'd1;
   end

   assign ready  = (warm_q == 5'(DEPTH));
   assign now_p  = pipe[SYNC_STAGES];
   assign prev_p = pipe[SYNC_STAGES+1];
   assign rd_now = !now_p.sel_n &&
                   (now_p.mode ? (now_p.stb_b && !now_p.stb_a) : !now_p.stb_b);

   // R2 / R9: a write pulse stems from a strobe rise under select, three edges back
   a_r2_write_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ready && reg_wr_o |-> (now_p.stb_a && !prev_p.stb_a && !now_p.sel_n));

   // R3: split-mode read strobe drives the bus
   a_r3_split_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
      ready && !now_p.mode && !now_p.sel_n && !now_p.stb_b |-> hb_data_oe_o);

   // R5: joined-mode read direction with data strobe drives the bus
   a_r5_joined_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
      ready && now_p.mode && !now_p.sel_n && now_p.stb_b && !now_p.stb_a |-> hb_data_oe_o);

   // R6: deselected bus neither writes nor drives
   a_r6_sel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ready && now_p.sel_n |-> !reg_wr_o && !hb_data_oe_o);

   // R7: joined-mode write needs direction low
   a_r7_joined_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      ready && reg_wr_o && now_p.mode |-> !now_p.stb_b);

   // R8: enable only during a read, released value is zero
   a_r8_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      ready && !rd_now |-> !hb_data_oe_o);

   a_r8_release_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hb_data_oe_o |-> (hb_data_o == '0));

   // R10: write pulse is a single cycle
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> !reg_wr_o);

endmodule

bind hostbus_port hostbus_port_chk #(
   .DATA_W      (DATA_W),
   .SYNC_STAGES (SYNC_STAGES)
) i_hostbus_port_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hb_sel_n_i   (hb_sel_n_i),
   .hb_stb_a_n_i (hb_stb_a_n_i),
   .hb_stb_b_i   (hb_stb_b_i),
   .hb_mode_i    (hb_mode_i),
   .hb_data_o    (hb_data_o),
   .hb_data_oe_o (hb_data_oe_o),
   .reg_wr_o     (reg_wr_o)
);

// File: tb/test_hostbus_port.sv
`timescale 1ns/1ps
module test_hostbus_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] din = '0;
   logic [6:0]  addr = '0;
   logic        sel_n = 1'b1;
   logic        stb_a = 1'b1;
   logic        stb_b = 1'b1;
   logic        mode = 1'b0;
   logic [15:0] dout;
   logic        oe;
   logic        wr;
   logic [6:0]  wr_addr;
   logic [15:0] wr_data;

   int          checks = 0;
   int          errors = 0;
   int          cycles = 0;
   logic [15:0] model [128];

   always #2 clk = ~clk;

   hostbus_port i_hostbus_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .hb_data_i    (din),
      .hb_addr_i    (addr),
      .hb_sel_n_i   (sel_n),
      .hb_stb_a_n_i (stb_a),
      .hb_stb_b_i   (stb_b),
      .hb_mode_i    (mode),
      .hb_data_o    (dout),
      .hb_data_oe_o (oe),
      .reg_wr_o     (wr),
      .reg_addr_o   (wr_addr),
      .reg_data_o   (wr_data)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 60000) begin
         errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic bit write_expected(input logic sel, input logic m, input logic dir);
      return sel && (!m || !dir);
   endfunction

   task automatic go_idle();
      sel_n = 1'b1; stb_a = 1'b1; stb_b = 1'b1;
   endtask

   // m: 0 split, 1 joined; dir used in joined mode only (1 = read direction)
   task automatic bus_write(input logic m, input logic sel, input logic dir,
                            input logic [6:0] a, input logic [15:0] d, input string req);
      int  pulses = 0;
      int  at = 0;
      bit  exp_wr;
      exp_wr = write_expected(sel, m, dir);
      @(negedge clk);
      mode = m; sel_n = ~sel; addr = a; din = d;
      stb_b = m ? dir : 1'b1;
      stb_a = 1'b0;
      repeat (3) @(negedge clk);
      stb_a = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (wr) begin
            pulses++;
            if (pulses == 1) begin
               at = k;
               chk(wr_addr == a, req, "write address", 32'(wr_addr), 32'(a));
               chk(wr_data == d, req, "write data", 32'(wr_data), 32'(d));
            end
         end
      end
      chk(pulses == (exp_wr ? 1 : 0), exp_wr ? req : (sel ? "R7" : "R6"),
          "write pulse count (R10)", 32'(pulses), exp_wr ? 32'd1 : 32'd0);
      if (exp_wr) begin
         chk(at == 3, "R9", "write pulse latency", 32'(at), 32'd3);
         model[a] = d;
      end
      go_idle();
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_read(input logic m, input logic sel, input logic [6:0] a, input string req);
      @(negedge clk);
      mode = m; sel_n = ~sel; addr = a;
      if (m) begin stb_b = 1'b1; stb_a = 1'b0; end
      else   begin stb_b = 1'b0; stb_a = 1'b1; end
      repeat (2) @(negedge clk);
      chk(oe == 1'b0, "R9", "enable before latency", 32'(oe), 32'd0);
      @(negedge clk);
      chk(oe == sel, sel ? req : "R6", "output enable", 32'(oe), 32'(sel));
      @(negedge clk);
      chk(dout == (sel ? model[a] : 16'h0), sel ? req : "R8", "read data",
          32'(dout), sel ? 32'(model[a]) : 32'd0);
      go_idle();
      repeat (4) @(negedge clk);
      chk(oe == 1'b0, "R8", "enable released", 32'(oe), 32'd0);
      chk(dout == 16'h0, "R8", "released value", 32'(dout), 32'd0);
      chk(wr == 1'b0, "R7", "no write after read", 32'(wr), 32'd0);
   endtask

   initial begin
      void'($urandom(32'h1F2E3D));
      for (int i = 0; i < 128; i++) model[i] = 16'h0;
      repeat (4) @(negedge clk);
      chk(wr == 1'b0, "R1", "write pulse in reset", 32'(wr), 32'd0);
      chk(oe == 1'b0, "R1", "enable in reset", 32'(oe), 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: reset contents
      bus_read(1'b0, 1'b1, 7'd0,   "R1");
      bus_read(1'b1, 1'b1, 7'd127, "R1");

      // directed writes and reads in both modes
      bus_write(1'b0, 1'b1, 1'b0, 7'd5,   16'hA5C3, "R2");
      bus_read (1'b0, 1'b1, 7'd5,  "R3");
      bus_write(1'b1, 1'b1, 1'b0, 7'd127, 16'hFFFF, "R4");
      bus_read (1'b1, 1'b1, 7'd127, "R5");
      bus_write(1'b1, 1'b1, 1'b1, 7'd5,   16'h1234, "R7");
      bus_read (1'b1, 1'b1, 7'd5,  "R7");
      bus_write(1'b0, 1'b0, 1'b0, 7'd5,   16'h4321, "R6");
      bus_read (1'b0, 1'b1, 7'd5,  "R6");
      bus_read (1'b0, 1'b0, 7'd5,  "R3");

      // R10: strobe held high long after rise gives one pulse
      begin
         int pulses = 0;
         @(negedge clk);
         mode = 1'b0; sel_n = 1'b0; addr = 7'd9; din = 16'h0F0F; stb_a = 1'b0;
         repeat (3) @(negedge clk);
         stb_a = 1'b1;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (wr) pulses++;
         end
         chk(pulses == 1, "R10", "pulses for held strobe", 32'(pulses), 32'd1);
         model[9] = 16'h0F0F;
         go_idle();
         repeat (3) @(negedge clk);
      end

      // overlap: split read held open while a write to the same word ends
      begin
         int pulses = 0;
         @(negedge clk);
         mode = 1'b0; sel_n = 1'b0; addr = 7'd33; din = 16'hBEEF;
         stb_b = 1'b0; stb_a = 1'b0;
         repeat (4) @(negedge clk);
         chk(oe == 1'b1 && dout == model[33], "R3", "overlap read before write",
             32'(dout), 32'(model[33]));
         stb_a = 1'b1;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (wr) pulses++;
            chk(oe == 1'b1, "R3", "overlap enable held", 32'(oe), 32'd1);
         end
         chk(pulses == 1, "R2", "overlap write pulses", 32'(pulses), 32'd1);
         chk(dout == 16'hBEEF, "R2", "overlap read sees new word", 32'(dout), 32'hBEEF);
         model[33] = 16'hBEEF;
         go_idle();
         repeat (4) @(negedge clk);
      end

      // constrained random mix
      for (int n = 0; n < 80; n++) begin
         int          op;
         logic        sel;
         logic        dir;
         logic [6:0]  a;
         logic [15:0] d;
         op  = int'($urandom % 4);
         sel = (($urandom % 8) != 0);
         dir = (($urandom % 6) == 0);
         a   = 7'($urandom);
         d   = 16'($urandom);
         case (op)
            0: bus_write(1'b0, sel, 1'b0, a, d, "R2");
            1: bus_write(1'b1, sel, dir,  a, d, "R4");
            2: bus_read (1'b0, sel, a, "R3");
            default: bus_read(1'b1, sel, a, "R5");
         endcase
      end

      // sweep of all words in joined mode
      for (int i = 0; i < 128; i += 9) bus_read(1'b1, 1'b1, 7'(i), "R5");

      summary();
      $finish;
   end

endmodule